// File: doc/BRIEF.md
# Wiper Register Bank with One-Hot Tap Decoder

This block holds the state behind one digitally controlled potentiometer. That state is a 6-bit wiper position register and four 6-bit preset registers. A command front-end, typically the serial protocol engine, issues single-cycle register commands on a small strobe interface. The commands load the wiper directly, store a preset, read either kind of register back, or copy a chosen preset into the wiper.

The wiper value drives a registered 64-line tap-select bus, with one line for each switch of the resistor ladder. At most one line is ever high. While reset is held, no line is high. Read results appear on an 8-bit bus whose two upper bits are always zero. A one-cycle valid pulse marks each new read result.

Top module: `wiper_bank_top`

## Requirements
- R1: While `rstN` is low, `tapSel` is all zeros and `rdValid` is low. After reset, the wiper register and all four presets read back as 0.
- R2: A command with `cmdValid`=1 and `cmdOp`=0 loads `cmdData` into the wiper register.
- R3: A command with `cmdOp`=2 loads `cmdData` into the preset selected by `cmdSel` (0 to 3). The other presets are left unchanged.
- R4: A command with `cmdOp`=4 copies the preset selected by `cmdSel` into the wiper register. The new value can be read by a command issued in the very next cycle.
- R5: A command with `cmdOp`=1 (read wiper) or `cmdOp`=3 (read the preset selected by `cmdSel`) raises `rdValid` for the single cycle after the strobe. In that cycle, `rdData` holds the register value as it stood when the strobe was issued.
- R6: `rdData[7:6]` is always 0. `rdData` keeps the last value read until the next read command.
- R7: `tapSel` has only bit `w` set, where `w` is the wiper value. It updates one clock after the wiper register changes, which is two clocks after the write or copy strobe. On the first clock after reset, bit 0 is set.
- R8: At no time are two or more bits of `tapSel` high.
- R9: A cycle with `cmdValid`=0, or with `cmdOp` equal to 5, 6 or 7, changes no register and does not raise `rdValid`.
- R10: The command decode issues at most one internal register strobe per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Single-cycle command strobe |
| cmdOp | input | 3 | Command code: 0 write wiper, 1 read wiper, 2 write preset, 3 read preset, 4 copy preset to wiper |
| cmdSel | input | 2 | Preset index for commands 2, 3 and 4 |
| cmdData | input | 6 | Write value for commands 0 and 2 |
| rdData | output | 8 | Read result, zero-extended |
| rdValid | output | 1 | High for one cycle when `rdData` carries a new result |
| tapSel | output | 64 | One-hot tap switch enable |

## Verification
Each command is driven in one cycle. Its read result and its `rdValid` pulse are checked just after the next rising edge. The `tapSel` value sampled at that same point must match the wiper value from before the command, because the decode adds one register stage. Preset writes and wiper copies are checked indirectly, through later read commands and the lagging tap bus. Every sample is taken two nanoseconds after a rising edge, and new inputs are applied on falling edges, so no check samples a value on the edge where it changes.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic [2:0] {
    OP_WR_WIPER  = 3'd0,
    OP_RD_WIPER  = 3'd1,
    OP_WR_PRESET = 3'd2,
    OP_RD_PRESET = 3'd3,
    OP_COPY      = 3'd4
  } wb_op_e;

  typedef struct packed {
    logic wrWiper;
    logic rdWiper;
    logic wrPreset;
    logic rdPreset;
    logic copy;
  } wb_strobe_t;

endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output wb_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      case (cmdOp)
        OP_WR_WIPER:  strobe.wrWiper  = 1'b1;
        OP_RD_WIPER:  strobe.rdWiper  = 1'b1;
        OP_WR_PRESET: strobe.wrPreset = 1'b1;
        OP_RD_PRESET: strobe.rdPreset = 1'b1;
        OP_COPY:      strobe.copy     = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe) <= 1); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strobe == '0)); // R9

endmodule

// File: rtl/wb_datapath.sv
module wb_datapath
  import wb_pkg::*;
#(
  parameter int VAL_W = 6,
  parameter int NREG  = 4,
  parameter int RD_W  = 8,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TAPS  = 1 << VAL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  wb_strobe_t       strobe,
  input  logic [SEL_W-1:0] sel,
  input  logic [VAL_W-1:0] data,
  output logic [RD_W-1:0]  rdData,
  output logic             rdValid,
  output logic [TAPS-1:0]  tapSel
);

  logic [VAL_W-1:0] wiper;
  logic [VAL_W-1:0] preset [NREG];
  logic [VAL_W-1:0] presetPick;
  logic [VAL_W-1:0] rdPick;
  logic [TAPS-1:0]  tapNext;

  // preset storage, one register per index
  for (genvar i = 0; i < NREG; i++) begin : g_preset
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        preset[i] <= '0;
      else if (strobe.wrPreset && (sel == SEL_W'(i)))
        preset[i] <= data;
    end
  end

  assign presetPick = preset[sel];

  // wiper register: direct load has priority over copy (never both)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wiper <= '0;
    else if (strobe.wrWiper)
      wiper <= data;
    else if (strobe.copy)
      wiper <= presetPick;
  end

  // read port
  assign rdPick = strobe.rdWiper ? wiper : presetPick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdWiper | strobe.rdPreset;
      if (strobe.rdWiper | strobe.rdPreset)
        rdData <= RD_W'(rdPick);
    end
  end

  // tap decoder, one comparator per switch, registered output
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapNext[t] = (wiper == VAL_W'(t));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tapSel <= '0;
    else
      tapSel <= tapNext;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (tapSel == '0 && !rdValid)); // R1

  AST_TAP_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tapSel)); // R8

  AST_TAP_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> tapSel[$past(wiper)]); // R7

  AST_COPY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copy |=> (wiper == $past(presetPick))); // R4

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrWiper |=> (wiper == $past(data))); // R2

  AST_RD_PAD: assert property (@(posedge clk) disable iff (!rstN)
    rdData[RD_W-1:VAL_W] == '0); // R6

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdWiper || strobe.rdPreset) |=> !rdValid); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdWiper || strobe.rdPreset) |=> $stable(rdData)); // R6

  AST_RD_WIPER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdWiper |=> (rdValid && rdData == RD_W'($past(wiper)))); // R5

endmodule

// File: rtl/wiper_bank_top.sv
module wiper_bank_top
  import wb_pkg::*;
#(
  parameter int VAL_W = 6,
  parameter int NREG  = 4,
  parameter int RD_W  = 8,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TAPS  = 1 << VAL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [SEL_W-1:0] cmdSel,
  input  logic [VAL_W-1:0] cmdData,
  output logic [RD_W-1:0]  rdData,
  output logic             rdValid,
  output logic [TAPS-1:0]  tapSel
);

  wb_strobe_t strobe;

  wb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .strobe   (strobe)
  );

  wb_datapath #(
    .VAL_W (VAL_W),
    .NREG  (NREG),
    .RD_W  (RD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sel     (cmdSel),
    .data    (cmdData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .tapSel  (tapSel)
  );

endmodule

// File: tb/wiper_bank_top_tb.sv
`timescale 1ns/1ps
module wiper_bank_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic [1:0]  cmdSel;
  logic [5:0]  cmdData;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [63:0] tapSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [5:0] mWiper;
  logic [5:0] mPreset [4];
  logic [7:0] mRd;

  always #5 clk = ~clk;

  wiper_bank_top u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSel(cmdSel), .cmdData(cmdData), .rdData(rdData),
    .rdValid(rdValid), .tapSel(tapSel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] tapOf(input logic [5:0] w);
    return 64'(1) << w;
  endfunction

  // issue one command, then check results just after the following edge
  task automatic step(input logic v, input logic [2:0] op,
                      input logic [1:0] s, input logic [5:0] d);
    logic [5:0] prevWiper;
    logic       expValid;
    cmdValid = v; cmdOp = op; cmdSel = s; cmdData = d;
    prevWiper = mWiper;
    expValid  = 1'b0;
    if (v) begin
      case (op)
        3'd0: mWiper = d;
        3'd1: begin mRd = {2'b00, mWiper}; expValid = 1'b1; end
        3'd2: mPreset[s] = d;
        3'd3: begin mRd = {2'b00, mPreset[s]}; expValid = 1'b1; end
        3'd4: mWiper = mPreset[s];
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    if (expValid) chk("R5 rdValid pulse", 64'(rdValid), 64'(1));
    else          chk("R9 rdValid quiet", 64'(rdValid), 64'(0));
    chk("R6 rdData value/pad/hold", 64'(rdData), 64'(mRd));
    chk("R7 tapSel lag", tapSel, tapOf(prevWiper));
    chk("R8 onehot", 64'($countones(tapSel)), 64'(1));
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b1; cmdValid = 1'b0; cmdOp = '0; cmdSel = '0; cmdData = '0;
    mWiper = '0; mRd = '0;
    for (int i = 0; i < 4; i++) mPreset[i] = '0;
    #1 rstN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 tapSel off in reset", tapSel, 64'(0));
      chk("R1 rdValid low in reset", 64'(rdValid), 64'(0));
    end
    // drive strobes during reset: must leave nothing behind
    cmdValid = 1'b1; cmdOp = 3'd0; cmdData = 6'd33;
    @(negedge clk);
    chk("R1 tapSel off with strobe in reset", tapSel, 64'(0));
    cmdValid = 1'b0;
    rstN = 1'b1;

    // R1: reset contents
    step(1'b1, 3'd1, 2'd0, 6'd0);
    for (int i = 0; i < 4; i++) step(1'b1, 3'd3, 2'(i), 6'd0);

    // R2 / R7: extreme taps
    step(1'b1, 3'd0, 2'd0, 6'd63);
    step(1'b0, 3'd0, 2'd0, 6'd0);
    step(1'b1, 3'd1, 2'd0, 6'd0);
    step(1'b1, 3'd0, 2'd0, 6'd0);
    step(1'b0, 3'd0, 2'd0, 6'd0);

    // R3 / R4: preset store then copy, read immediately after copy
    for (int i = 0; i < 4; i++) step(1'b1, 3'd2, 2'(i), 6'(10 + 13 * i));
    for (int i = 0; i < 4; i++) step(1'b1, 3'd3, 2'(i), 6'd0);
    step(1'b1, 3'd4, 2'd3, 6'd0);
    step(1'b1, 3'd1, 2'd0, 6'd0);
    step(1'b1, 3'd4, 2'd1, 6'd0);
    step(1'b1, 3'd1, 2'd0, 6'd0);

    // R9: illegal codes and idle cycles with live data must not write
    for (int op = 5; op < 8; op++) step(1'b1, 3'(op), 2'd2, 6'd7);
    step(1'b0, 3'd0, 2'd0, 6'd17);
    step(1'b0, 3'd2, 2'd2, 6'd17);
    step(1'b1, 3'd1, 2'd0, 6'd0);
    step(1'b1, 3'd3, 2'd2, 6'd0);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 3'($urandom % 8), 2'($urandom % 4), 6'($urandom % 64));
    end

    // R1 again: reset in the middle of operation clears everything
    @(negedge clk);
    rstN = 1'b0;
    #2;
    chk("R1 tapSel cleared by async reset", tapSel, 64'(0));
    mWiper = '0; mRd = '0;
    for (int i = 0; i < 4; i++) mPreset[i] = '0;
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 3'd1, 2'd0, 6'd0);
    step(1'b1, 3'd3, 2'd3, 6'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule